// File: doc/BRIEF.md
# Routable Multi-Output Interrupt Controller

This block gathers 32 level-sensitive interrupt sources and steers each of them to one of 15 request lines. Software uses a small 32-bit register bus to reach three kinds of state: an enable mask, a read-only view of the input levels, and a set of routing words. Each routing word holds a 4-bit code for each of eight sources.

A source drives its chosen request line while three things are true at once: its level is active, its enable bit is set, and its routing code is nonzero. A request line is the OR of every source that meets these conditions and is routed to it. The inputs pass through a two-stage synchroniser before they are used. The request lines come from flops.

Routing words are packed in descending source order. The word at the lowest routing address holds the highest-numbered sources.

Top module: `irq_router`

## Requirements
- R1: After reset, the enable mask and every routing word read as zero and all request lines are low. Writing zeros to the mask and to the routing words after reset is accepted and leaves every line low.
- R2: The mask register is at byte offset 0x00. A write stores all 32 bits, and a read returns them. Bit n enables source n.
- R3: The status register is at byte offset 0x04. It returns the input levels, one bit per source, whatever the mask holds. A change on an input appears in status after two clock edges and not after one.
- R4: Writes to offset 0x04 change neither the status value nor the mask.
- R5: A routing code of 0 disconnects its source. A code c in the range 1 to 15 connects the source to request line c-1. Code 15 reaches line 14.
- R6: The routing code of source n is in the word at byte offset 0x08 + 4*(3 - n/8), in bits [4*(n mod 8)+3 : 4*(n mod 8)].
- R7: Request line k is high exactly when some source s has its enable bit, its status bit and a routing code equal to k+1 all set. The line reacts one clock edge after status changes, so three edges after an input changes.
- R8: A source whose enable bit is clear never drives a line. A change to the mask reaches the request lines one clock edge after the write.
- R9: Reads of unmapped offsets return zero. Unmapped offsets include 0x18 and above, and any address whose two low bits are not zero. Writes to them change no register.
- R10: Two or more sources routed to the same line combine by OR. The line stays high while any of them is held active and falls once none is.
- R11: A write to a routing word replaces all 32 bits of it, and a read returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Raw level-sensitive interrupt sources |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational from register state |
| irq_out | output | 15 | Request lines, registered |

## Verification
Each result has a fixed latency:
- A register write is visible on `rdata` as soon as the write edge has passed.
- An input change reaches status after two edges and the request lines after three.
- A mask or routing write reaches the request lines after one edge.

The driver tags each expected item with the cycle in which it falls due. The monitor samples a quarter period after that rising edge. Latency is checked on both sides of each boundary: status one edge after an input change must still show the old value, and a request line two edges after an input change must still be low.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
   // Byte offsets of the register groups
   localparam int unsigned OFS_MASK  = 'h00;
   localparam int unsigned OFS_STAT  = 'h04;
   localparam int unsigned OFS_ROUTE = 'h08;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_MASK  = 2'd1,
      SEL_STAT  = 2'd2,
      SEL_ROUTE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/irqr_sync.sv
module irqr_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      assert (STAGES >= 2) else $error("irqr_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[i] <= '0;
         else        stage_q[i] <= stage_q[i-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/irqr_regs.sv
module irqr_regs
   import irqr_pkg::*;
#(
   parameter int N_SRC  = 32,
   parameter int CODE_W = 4,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [DATA_W-1:0]       wdata,
   input  logic [N_SRC-1:0]        status,
   output logic [N_SRC-1:0]        mask_q,
   output logic [N_SRC*CODE_W-1:0] route_flat,
   output logic [DATA_W-1:0]       rdata
);
   localparam int FPW      = DATA_W / CODE_W;
   localparam int N_RW     = N_SRC / FPW;
   localparam int WA_W     = ADDR_W - 2;
   localparam int RW_IDX_W = (N_RW > 1) ? $clog2(N_RW) : 1;
   localparam logic [WA_W-1:0] WA_MASK  = WA_W'(OFS_MASK / 4);
   localparam logic [WA_W-1:0] WA_STAT  = WA_W'(OFS_STAT / 4);
   localparam logic [WA_W-1:0] WA_ROUTE = WA_W'(OFS_ROUTE / 4);
   localparam logic [WA_W-1:0] WA_NRW   = WA_W'(N_RW);

   logic [WA_W-1:0]     wa;
   logic [WA_W-1:0]     rw_off;
   logic                aligned;
   logic                in_route;
   logic [RW_IDX_W-1:0] rw_idx;
   reg_sel_e            sel;
   logic [DATA_W-1:0]   rword_q [N_RW];

   assign wa       = addr[ADDR_W-1:2];
   assign aligned  = (addr[1:0] == 2'b00);
   assign rw_off   = wa - WA_ROUTE;
   assign in_route = aligned && (wa >= WA_ROUTE) && (rw_off < WA_NRW);
   assign rw_idx   = rw_off[RW_IDX_W-1:0];

   always_comb begin
      sel = SEL_NONE;
      if (aligned && wa == WA_MASK)      sel = SEL_MASK;
      else if (aligned && wa == WA_STAT) sel = SEL_STAT;
      else if (in_route)                 sel = SEL_ROUTE;
   end

   // Enable mask
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        mask_q <= '0;
      else if (wr_en && sel == SEL_MASK) mask_q <= wdata[N_SRC-1:0];
   end

   // Routing words; word w holds the highest sources first
   for (genvar w = 0; w < N_RW; w++) begin : g_rword
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rword_q[w] <= '0;
         else if (wr_en && sel == SEL_ROUTE && rw_idx == RW_IDX_W'(w))
            rword_q[w] <= wdata;
      end
      for (genvar f = 0; f < FPW; f++) begin : g_field
         localparam int SRC = (N_RW - 1 - w) * FPW + f;
         assign route_flat[SRC*CODE_W +: CODE_W] = rword_q[w][f*CODE_W +: CODE_W];
      end
   end

   // Read mux
   always_comb begin
      unique case (sel)
         SEL_MASK:  rdata = DATA_W'(mask_q);
         SEL_STAT:  rdata = DATA_W'(status);
         SEL_ROUTE: rdata = rword_q[rw_idx];
         default:   rdata = '0;
      endcase
   end

   // R2
   mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFS_MASK)) |=> mask_q == $past(wdata[N_SRC-1:0]));

   // R4
   stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFS_STAT)) |=> ($stable(mask_q) && $stable(route_flat)));

   // R9
   unmapped_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !aligned) |=> ($stable(mask_q) && $stable(route_flat)));
endmodule

// File: rtl/irqr_matrix.sv
module irqr_matrix #(
   parameter int N_SRC  = 32,
   parameter int N_OUT  = 15,
   parameter int CODE_W = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_SRC-1:0]        status,
   input  logic [N_SRC-1:0]        mask,
   input  logic [N_SRC*CODE_W-1:0] route_flat,
   output logic [N_OUT-1:0]        irq_out
);
   logic [N_SRC-1:0] live;
   logic [N_OUT-1:0] hit;

   assign live = mask & status;

   for (genvar k = 0; k < N_OUT; k++) begin : g_line
      logic [N_SRC-1:0] to_k;
      for (genvar s = 0; s < N_SRC; s++) begin : g_src
         assign to_k[s] = (route_flat[s*CODE_W +: CODE_W] == CODE_W'(k + 1));
      end
      assign hit[k] = |(live & to_k);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_out <= '0;
      else        irq_out <= hit;
   end

   // R8
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |=> (irq_out == '0));

   // R5
   unrouted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (route_flat == '0) |=> (irq_out == '0));

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mask & status) == '0) |=> (irq_out == '0));

   // R10
   line_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(irq_out) <= $countones($past(mask & status))));
endmodule

// File: rtl/irq_router.sv
module irq_router #(
   parameter int N_SRC       = 32,
   parameter int N_OUT       = 15,
   parameter int CODE_W      = 4,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  irq_in,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [N_OUT-1:0]  irq_out
);
   localparam int FPW = DATA_W / CODE_W;

   initial begin
      assert (N_OUT <= (2**CODE_W) - 1) else $error("irq_router: N_OUT exceeds code space");
      assert (DATA_W % CODE_W == 0)     else $error("irq_router: DATA_W not a multiple of CODE_W");
      assert (N_SRC % FPW == 0)         else $error("irq_router: N_SRC not a multiple of fields per word");
      assert (N_SRC <= DATA_W)          else $error("irq_router: N_SRC wider than a register");
      assert (ADDR_W >= 5)              else $error("irq_router: ADDR_W too narrow for the map");
   end

   logic [N_SRC-1:0]        status;
   logic [N_SRC-1:0]        mask_q;
   logic [N_SRC*CODE_W-1:0] route_flat;

   irqr_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (irq_in),
      .q     (status)
   );

   irqr_regs #(.N_SRC(N_SRC), .CODE_W(CODE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .addr       (addr),
      .wdata      (wdata),
      .status     (status),
      .mask_q     (mask_q),
      .route_flat (route_flat),
      .rdata      (rdata)
   );

   irqr_matrix #(.N_SRC(N_SRC), .N_OUT(N_OUT), .CODE_W(CODE_W)) u_matrix (
      .clk        (clk),
      .rst_n      (rst_n),
      .status     (status),
      .mask       (mask_q),
      .route_flat (route_flat),
      .irq_out    (irq_out)
   );

   // R3
   status_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[0]) |-> $past(irq_in[0], 2));
endmodule

// File: tb/irq_router_test.sv
module irq_router_test;
   localparam int CLK_P = 10;

   typedef struct {
      int          due;
      bit          is_rd;
      logic [31:0] exp;
      string       req;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_in = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [14:0] irq_out;

   int    cyc = 0;
   int    n_tests = 0;
   int    n_fail = 0;
   bit    finished = 1'b0;
   item_t sb_q[$];

   irq_router uut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
   );

   always #(CLK_P/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: pop due items a quarter period after the rising edge
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_P/4);
         while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            act = it.is_rd ? rdata : {17'b0, irq_out};
            n_tests++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s %s: actual %h expected %h", it.req,
                        it.is_rd ? "rdata" : "irq_out", act, it.exp);
            end
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
      item_t it;
      addr = a;
      it.due = cyc + 1; it.is_rd = 1'b1; it.exp = e; it.req = req;
      sb_q.push_back(it);
      @(negedge clk);
   endtask

   task automatic chk_out(input logic [14:0] e, input int lat, input string req);
      item_t it;
      it.due = cyc + lat; it.is_rd = 1'b0; it.exp = {17'b0, e}; it.req = req;
      sb_q.push_back(it);
      idle(lat);
   endtask

   task automatic summary;
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1: reset state and software init writes
      rd(8'h00, 32'h0, "R1");
      rd(8'h08, 32'h0, "R1");
      rd(8'h14, 32'h0, "R1");
      chk_out(15'h0, 1, "R1");
      wr(8'h00, 32'h0);
      for (int w = 0; w < 4; w++) wr(8'(8 + 4*w), 32'h0);
      chk_out(15'h0, 1, "R1");

      // R2: mask read/write
      wr(8'h00, 32'hA5A5_0F0F);
      rd(8'h00, 32'hA5A5_0F0F, "R2");
      wr(8'h00, 32'h0);
      rd(8'h00, 32'h0, "R2");

      // R3: status latency and independence from mask
      irq_in = 32'h8000_0001;
      rd(8'h04, 32'h0, "R3");
      rd(8'h04, 32'h8000_0001, "R3");

      // R4: status write ignored
      wr(8'h04, 32'hFFFF_FFFF);
      rd(8'h04, 32'h8000_0001, "R4");
      rd(8'h00, 32'h0, "R4");

      // R6/R11: routing word for sources 24..31 at 0x08
      wr(8'h08, 32'h1234_5678);
      rd(8'h08, 32'h1234_5678, "R11");
      wr(8'h00, 32'h8000_0000);
      chk_out(15'h0001, 1, "R6");

      // R7: input-to-line latency, source 24 code 8 -> line 7
      wr(8'h00, 32'h8100_0000);
      chk_out(15'h0001, 1, "R7");
      irq_in = 32'h8100_0001;
      chk_out(15'h0001, 2, "R7");
      chk_out(15'h0081, 1, "R7");

      // R8: mask removes source 31
      wr(8'h00, 32'h0100_0000);
      chk_out(15'h0080, 1, "R8");

      // R5: code 0 disconnected, code 15 -> line 14
      wr(8'h14, 32'h0000_00F0);
      irq_in = 32'h0000_0003;
      idle(2);
      wr(8'h00, 32'h0000_0003);
      chk_out(15'h4000, 1, "R5");

      // R10: sources 16 and 23 both on line 2
      wr(8'h0C, 32'h3000_0003);
      wr(8'h00, 32'h0081_0000);
      irq_in = 32'h0001_0000;
      chk_out(15'h0004, 3, "R10");
      irq_in = 32'h0081_0000;
      chk_out(15'h0004, 3, "R10");
      irq_in = 32'h0080_0000;
      chk_out(15'h0004, 3, "R10");
      idle(5);
      chk_out(15'h0004, 1, "R10");
      irq_in = 32'h0;
      chk_out(15'h0004, 2, "R10");
      chk_out(15'h0000, 1, "R10");

      // R9: unmapped offsets
      wr(8'h18, 32'hFFFF_FFFF);
      wr(8'h01, 32'hFFFF_FFFF);
      rd(8'h18, 32'h0, "R9");
      rd(8'h40, 32'h0, "R9");
      rd(8'h02, 32'h0, "R9");
      rd(8'h00, 32'h0081_0000, "R9");
      rd(8'h08, 32'h1234_5678, "R9");

      // R11: whole-word replace, then source 8 code 2 -> line 1
      wr(8'h10, 32'hFFFF_FFFF);
      rd(8'h10, 32'hFFFF_FFFF, "R11");
      wr(8'h10, 32'h0000_0002);
      rd(8'h10, 32'h0000_0002, "R11");
      wr(8'h00, 32'h0000_0100);
      irq_in = 32'h0000_0100;
      chk_out(15'h0002, 3, "R11");

      // R1: reset mid-run
      irq_in = 32'h0;
      idle(3);
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(1);
      rd(8'h00, 32'h0, "R1");
      rd(8'h10, 32'h0, "R1");
      chk_out(15'h0, 1, "R1");

      idle(2);
      if (sb_q.size() != 0) begin
         n_tests++; n_fail++;
         $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
      end
      summary();
   end
endmodule